// File: doc/BRIEF.md
# Converter Output Coding and Range Flag Stage

This stage sits between the digital correction logic of a 10-bit converter and its data bus. Each clock it takes one corrected result in offset-binary form, plus separate indications that the input went above the positive or below the negative full-scale limit. It registers a coded word and an out-of-range flag for that sample and drives both onto tri-state outputs.

A coding select input picks straight binary or two's complement. Two's complement is made by inverting only the top bit. A sample that is over or under range is clamped to the matching full-scale code before coding is applied. An active-high disable input floats every data and flag output. The capture register keeps loading while the outputs float, so the newest sample appears as soon as the outputs are enabled again. A ready output follows the clock once reset is over, so the data is stable on its falling edge.

Top module: `adc_fmt_stage`

## Requirements
- R1: With `fmt_bin` low and no range indication, one clock after a sample `dout` equals the offset-binary input with bit 9 inverted and bits 8..0 unchanged.
- R2: With `fmt_bin` high and no range indication, one clock after a sample `dout` equals the offset-binary input unchanged.
- R3: When `over_rng` is high the sample is clamped to offset-binary 0x3FF, so `dout` is 0x3FF in straight binary and 0x1FF in two's complement. `over_rng` wins when both indications are high.
- R4: When only `under_rng` is high the sample is clamped to offset-binary 0x000, so `dout` is 0x000 in straight binary and 0x200 in two's complement.
- R5: `oor` is high exactly when the sample shown on `dout` had `over_rng` or `under_rng` high. It is registered at the same edge as that sample.
- R6: While `hiz` is high every bit of `dout` and `oor` is high impedance. The capture register keeps loading, and when `hiz` falls the outputs show the most recent sample at once, with no clock edge needed.
- R7: `drdy` is low while `rst_n` is low. After the first clock edge with reset released it equals `clk`, so new data appears on its rising edge and is stable through its falling edge.
- R8: While `rst_n` is low, `dout` is 0x000 and `oor` is low, provided `hiz` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; capture on rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| code | input | 10 | Corrected result, offset binary |
| over_rng | input | 1 | Input above positive full scale |
| under_rng | input | 1 | Input below negative full scale |
| fmt_bin | input | 1 | 1 = straight binary, 0 = two's complement |
| hiz | input | 1 | 1 = float all data and flag outputs |
| dout | output | 10 | Coded data bus, tri-state |
| oor | output | 1 | Out-of-range flag, tri-state |
| drdy | output | 1 | Data ready, follows clock after reset |

## Verification
The assertions check four rules on every enabled cycle: top-bit inversion against straight pass-through, clamping to full scale in both codings, and the pairing of the flag with the sample it belongs to. The floating of outputs while disabled, the immediate return of the newest sample without a clock edge, and the phase of `drdy` against the clock are shown only by the bench scenarios. Those scenarios sample between edges and compare with a behavioural model that sweeps codes across full scale and past it in both codings.

// File: rtl/adc_fmt_stage.sv
module adc_fmt_stage #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] code,
  input  logic         over_rng,
  input  logic         under_rng,
  input  logic         fmt_bin,
  input  logic         hiz,
  output tri   [W-1:0] dout,
  output tri           oor,
  output logic         drdy
);
  localparam logic [W-1:0] FS_POS = {W{1'b1}};
  localparam logic [W-1:0] FS_NEG = {W{1'b0}};
  localparam logic [W-1:0] MSB_M  = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] clamped, coded, word_q;
  logic         flag_q, run_q;

  assign clamped = over_rng  ? FS_POS :
                   under_rng ? FS_NEG : code;
  assign coded   = fmt_bin ? clamped : (clamped ^ MSB_M);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      flag_q <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      word_q <= coded;
      flag_q <= over_rng | under_rng;
      run_q  <= 1'b1;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_drv
    assign dout[i] = hiz ? 1'bz : word_q[i];
  end
  assign oor  = hiz ? 1'bz : flag_q;
  assign drdy = clk & run_q;
endmodule

// File: rtl/adc_fmt_stage_chk.sv
module adc_fmt_stage_chk #(
  parameter int W = 10
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] code,
  input logic         over_rng,
  input logic         under_rng,
  input logic         fmt_bin,
  input logic         hiz,
  input logic [W-1:0] dout,
  input logic         oor
);
  p_twos_msb_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!over_rng && !under_rng && !fmt_bin) |=>
      (hiz || (dout[W-1] == !$past(code[W-1]) && dout[W-2:0] == $past(code[W-2:0]))));

  p_bin_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!over_rng && !under_rng && fmt_bin) |=> (hiz || dout == $past(code)));

  p_clamp_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
    over_rng |=> (hiz || dout == ($past(fmt_bin) ? {W{1'b1}} : {1'b0, {(W-1){1'b1}}})));

  p_clamp_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (under_rng && !over_rng) |=> (hiz || dout == ($past(fmt_bin) ? {W{1'b0}} : {1'b1, {(W-1){1'b0}}})));

  p_flag_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (hiz || oor == ($past(over_rng) || $past(under_rng))));
endmodule

bind adc_fmt_stage adc_fmt_stage_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .code(code), .over_rng(over_rng),
  .under_rng(under_rng), .fmt_bin(fmt_bin), .hiz(hiz),
  .dout(dout), .oor(oor)
);

// File: tb/sim_adc_fmt_stage.sv
module sim_adc_fmt_stage;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] code = '0;
  logic       over_rng = 1'b0, under_rng = 1'b0, fmt_bin = 1'b1, hiz = 1'b0;
  wire  [9:0] dout;
  wire        oor;
  logic       drdy;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  adc_fmt_stage u0 (
    .clk(clk), .rst_n(rst_n), .code(code), .over_rng(over_rng),
    .under_rng(under_rng), .fmt_bin(fmt_bin), .hiz(hiz),
    .dout(dout), .oor(oor), .drdy(drdy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [9:0] model(input logic [9:0] c, input logic ov,
                                       input logic un, input logic fb);
    logic [9:0] v;
    if (ov) v = 10'h3FF;
    else if (un) v = 10'h000;
    else v = c;
    if (!fb) v[9] = ~v[9];
    return v;
  endfunction

  task automatic chk(input string req, input logic [10:0] act, input logic [10:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // apply inputs in low phase, clock them in, verify in high and low phase
  task automatic step(input string req, input logic [9:0] c, input logic ov,
                      input logic un, input logic fb, input logic hz);
    code = c; over_rng = ov; under_rng = un; fmt_bin = fb; hiz = hz;
    @(posedge clk); #2;
    chk("R7 drdy high", {10'd0, drdy}, 11'd1);
    @(negedge clk); #1;
    chk("R7 drdy low", {10'd0, drdy}, 11'd0);
    if (hz) chk({req, " R6 hiz"}, {dout, oor}, {10'bz, 1'bz});
    else    chk(req, {dout, oor}, {model(c, ov, un, fb), ov | un});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    code = 10'h2A5;
    over_rng = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R8 reset data/flag", {dout, oor}, 11'd0);
    @(posedge clk); #2;
    chk("R7 drdy in reset", {10'd0, drdy}, 11'd0);
    @(negedge clk);
    rst_n = 1'b1;
    over_rng = 1'b0;

    // sweep, both codings (R1, R2)
    for (int fb = 0; fb < 2; fb++) begin
      for (int c = 0; c < 1024; c += 37)
        step(fb ? "R2 binary" : "R1 twos", 10'(c), 1'b0, 1'b0, 1'(fb), 1'b0);
      step(fb ? "R2 binary edge" : "R1 twos edge", 10'h000, 1'b0, 1'b0, 1'(fb), 1'b0);
      step(fb ? "R2 binary edge" : "R1 twos edge", 10'h1FF, 1'b0, 1'b0, 1'(fb), 1'b0);
      step(fb ? "R2 binary edge" : "R1 twos edge", 10'h200, 1'b0, 1'b0, 1'(fb), 1'b0);
      step(fb ? "R2 binary edge" : "R1 twos edge", 10'h3FF, 1'b0, 1'b0, 1'(fb), 1'b0);
      // clamping and flag pairing (R3, R4, R5)
      step("R3 over clamp", 10'h123, 1'b1, 1'b0, 1'(fb), 1'b0);
      step("R5 flag clears", 10'h123, 1'b0, 1'b0, 1'(fb), 1'b0);
      step("R4 under clamp", 10'h3F0, 1'b0, 1'b1, 1'(fb), 1'b0);
      step("R3 both high, over wins", 10'h055, 1'b1, 1'b1, 1'(fb), 1'b0);
      step("R5 flag clears", 10'h055, 1'b0, 1'b0, 1'(fb), 1'b0);
    end

    // R6: float, keep converting, re-enable without a clock edge
    step("R6", 10'h0F0, 1'b0, 1'b0, 1'b1, 1'b1);
    step("R6", 10'h00F, 1'b1, 1'b0, 1'b1, 1'b1);
    step("R6", 10'h3C3, 1'b0, 1'b0, 1'b0, 1'b1);
    hiz = 1'b0; #1;
    chk("R6 immediate reenable", {dout, oor}, {model(10'h3C3, 1'b0, 1'b0, 1'b0), 1'b0});
    step("R6 after reenable", 10'h111, 1'b0, 1'b1, 1'b0, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule